// File: doc/BRIEF.md
# ULPI Link Receive-to-Transmit Turnaround Sequencer

This block is the link-side bus sequencer for a 4-bit ULPI data path. It watches the direction pin to tell when the PHY owns the bus and passes received nibbles up as a plain registered receive output. When the PHY hands the bus back, the sequencer observes the one-clock turnaround. It then holds off any transmit for a programmable decision delay counted in ULPI clocks, which keeps the reply inside the high-speed interpacket window.

Transmit data comes from a packet source over a valid/ready stream. The first word of each packet is the transmit command; the rest are the data nibbles. The head word sits on the bus until the PHY raises NXT, and only then does the stream advance. After the last word is taken, the sequencer raises STP for one clock and returns the bus to idle (zero). If the PHY takes the bus back in the middle of a packet, the sequencer stops driving and flags an abort pulse. It then consumes the rest of that packet from the stream, so that the source stays aligned on packet boundaries.

Back-pressure rules for the transmit stream are as follows. `tx_ready` is combinational and depends on `ulpi_nxt` and `ulpi_dir`. A word moves on any clock edge where `tx_valid` and `tx_ready` are both high. Once a packet's first word has been taken, the source keeps `tx_valid` high with the next word and holds each word stable until it is accepted, up to and including the word marked `tx_last`.

Top module: `ulpi_ta_seq`

## Requirements
- R1: `ulpi_data_oe` is low in every cycle in which `ulpi_dir` is high. It is also low in the turnaround cycle, which is the cycle where `ulpi_dir` is low but was high at the previous clock edge.
- R2: While the link owns the bus and no transmit or stop is in progress, `ulpi_data_oe` is high, `ulpi_data_o` is 0, `ulpi_stp` is low and `tx_ready` is low.
- R3: Let E0 be the first clock edge at which `ulpi_dir` is sampled low after being high. If `tx_valid` is already high, the command word (the head of the stream) first appears on `ulpi_data_o` just after edge E0+d+1, where d is the effective delay. Before that, the bus shows idle.
- R4: The effective delay d is `dly_cfg`, clamped to the range 1 to 14: a value of 0 gives 1 and a value of 15 gives 14. `dly_clamped` is high exactly when `dly_cfg` is 0 or 15.
- R5: During a transmit, `ulpi_data_o` equals `tx_data`, and `tx_ready` equals `ulpi_nxt`. A word is consumed only on an edge where `ulpi_nxt` is high.
- R6: In the cycle after the word marked `tx_last` is accepted, `ulpi_stp` is high and `ulpi_data_o` is 0. In the following cycle, `ulpi_stp` is low again and the bus is idle.
- R7: If `ulpi_dir` rises during a transmit, no further word is taken on the bus and `ulpi_stp` stays low. `tx_abort` is high for exactly the one cycle after that edge. From then on, `tx_ready` stays high until the rest of the packet, through `tx_last`, has been consumed, after which `tx_ready` returns low.
- R8: After every clock edge at which `ulpi_dir` is sampled high and was also high at the previous edge, `rx_valid` is 1 and `rx_data` holds the sampled `ulpi_data_i`. After any other edge, `rx_valid` is 0.
- R9: During and after reset with `ulpi_dir` low, the block is idle. That means `ulpi_data_oe` is 1, `ulpi_data_o` is 0, and `ulpi_stp`, `tx_ready`, `tx_abort` and `rx_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ULPI clock |
| rst | input | 1 | Synchronous reset, active high |
| ulpi_dir | input | 1 | Bus direction from the PHY; high means the PHY drives |
| ulpi_nxt | input | 1 | PHY accepts the current transmit word |
| ulpi_data_i | input | DW (4) | Bus data sampled from the PHY |
| ulpi_data_o | output | DW (4) | Bus data driven by the link |
| ulpi_data_oe | output | 1 | Link output enable for the data bus |
| ulpi_stp | output | 1 | End-of-transmit strobe to the PHY |
| dly_cfg | input | CW (4) | Requested decision delay in clocks |
| dly_clamped | output | 1 | Requested delay lies outside 1 to 14 |
| tx_valid | input | 1 | Transmit stream word is valid |
| tx_ready | output | 1 | Transmit stream word is consumed at this edge |
| tx_data | input | DW (4) | Transmit word; the first word of a packet is the command |
| tx_last | input | 1 | Marks the final word of a packet |
| tx_abort | output | 1 | One-cycle pulse: the transmit was cut off by the PHY |
| rx_valid | output | 1 | Received nibble is valid |
| rx_data | output | DW (4) | Received nibble |

## Verification
The assertions take several things for granted about the inputs. `dly_cfg` stays steady from the end of a receive until the reply's first word is accepted. `ulpi_dir` stays high while an aborted packet is being consumed. The packet source keeps `tx_valid` high across a packet once it has started. The stimulus meets all of this by changing `dly_cfg` only while the bus is idle, and by holding the PHY's direction high through every drain. The bench PHY model uses random receive lengths, random receive-end lags of three to eight clocks, random NXT stalls and random abort points, along with directed runs at the two clamp limits and at the worst-case lag of eight clocks.

// File: rtl/ulpi_ta_pkg.sv
package ulpi_ta_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SEND  = 2'd1,
    TX_STOP  = 2'd2,
    TX_DRAIN = 2'd3
  } tx_state_e;
endpackage

// File: rtl/ulpi_dly_clamp.sv
module ulpi_dly_clamp #(
  parameter int CW   = 4,
  parameter int DMIN = 1,
  parameter int DMAX = 14
) (
  input  logic [CW-1:0] cfg,
  output logic [CW-1:0] eff,
  output logic          clamped
);
  localparam logic [CW-1:0] LO = CW'(DMIN);
  localparam logic [CW-1:0] HI = CW'(DMAX);

  always_comb begin
    if (cfg < LO) begin
      eff     = LO;
      clamped = 1'b1;
    end else if (cfg > HI) begin
      eff     = HI;
      clamped = 1'b1;
    end else begin
      eff     = cfg;
      clamped = 1'b0;
    end
  end
endmodule

// File: rtl/ulpi_holdoff.sv
module ulpi_holdoff #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir,
  input  logic [CW-1:0] eff,
  output logic          bus_free,
  output logic          hold_done
);
  logic          dir_q;
  logic [CW-1:0] cnt;

  // Count starts at the first edge that sees the bus handed back.
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= dir;
      cnt   <= '0;
    end else begin
      dir_q <= dir;
      if (dir_q && !dir)
        cnt <= eff;
      else if (cnt != '0)
        cnt <= cnt - CW'(1);
    end
  end

  assign bus_free  = !dir && !dir_q;
  assign hold_done = (cnt == '0);
endmodule

// File: rtl/ulpi_rx_capture.sv
module ulpi_rx_capture #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir,
  input  logic [DW-1:0] data_i,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data
);
  logic dir_q;
  logic owned;

  assign owned = dir && dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q    <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      dir_q    <= dir;
      rx_valid <= owned;
      if (owned)
        rx_data <= data_i;
    end
  end
endmodule

// File: rtl/ulpi_tx_fsm.sv
module ulpi_tx_fsm
  import ulpi_ta_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir,
  input  logic          nxt,
  input  logic          bus_free,
  input  logic          hold_done,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_last,
  output logic          tx_ready,
  output logic          tx_abort,
  output logic [DW-1:0] data_o,
  output logic          stp
);
  tx_state_e st, st_nx;
  logic      take;

  always_comb begin
    tx_ready = 1'b0;
    data_o   = '0;
    stp      = 1'b0;
    case (st)
      TX_SEND: begin
        tx_ready = nxt && !dir;
        data_o   = tx_data;
      end
      TX_STOP:  stp      = 1'b1;
      TX_DRAIN: tx_ready = 1'b1;
      default: ;
    endcase
  end

  assign take = tx_valid && tx_ready;

  always_comb begin
    st_nx = st;
    case (st)
      TX_IDLE:
        if (tx_valid && bus_free && hold_done) st_nx = TX_SEND;
      TX_SEND:
        if (dir)                  st_nx = TX_DRAIN;
        else if (take && tx_last) st_nx = TX_STOP;
      TX_STOP:
        st_nx = TX_IDLE;
      TX_DRAIN:
        if (take && tx_last)      st_nx = TX_IDLE;
      default:
        st_nx = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= TX_IDLE;
      tx_abort <= 1'b0;
    end else begin
      st       <= st_nx;
      tx_abort <= (st == TX_SEND) && dir;
    end
  end
endmodule

// File: rtl/ulpi_ta_seq.sv
module ulpi_ta_seq #(
  parameter int DW   = 4,
  parameter int CW   = 4,
  parameter int DMIN = 1,
  parameter int DMAX = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ulpi_dir,
  input  logic          ulpi_nxt,
  input  logic [DW-1:0] ulpi_data_i,
  output logic [DW-1:0] ulpi_data_o,
  output logic          ulpi_data_oe,
  output logic          ulpi_stp,
  input  logic [CW-1:0] dly_cfg,
  output logic          dly_clamped,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_last,
  output logic          tx_abort,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data
);
  logic [CW-1:0] dly_eff;
  logic          bus_free;
  logic          hold_done;

  ulpi_dly_clamp #(.CW(CW), .DMIN(DMIN), .DMAX(DMAX)) u_clamp (
    .cfg     (dly_cfg),
    .eff     (dly_eff),
    .clamped (dly_clamped)
  );

  ulpi_holdoff #(.CW(CW)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .dir       (ulpi_dir),
    .eff       (dly_eff),
    .bus_free  (bus_free),
    .hold_done (hold_done)
  );

  ulpi_rx_capture #(.DW(DW)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .dir      (ulpi_dir),
    .data_i   (ulpi_data_i),
    .rx_valid (rx_valid),
    .rx_data  (rx_data)
  );

  ulpi_tx_fsm #(.DW(DW)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .dir       (ulpi_dir),
    .nxt       (ulpi_nxt),
    .bus_free  (bus_free),
    .hold_done (hold_done),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .tx_ready  (tx_ready),
    .tx_abort  (tx_abort),
    .data_o    (ulpi_data_o),
    .stp       (ulpi_stp)
  );

  assign ulpi_data_oe = bus_free;
endmodule

// File: rtl/ulpi_ta_seq_chk.sv
module ulpi_ta_seq_chk #(
  parameter int CW   = 4,
  parameter int DMIN = 1,
  parameter int DMAX = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          ulpi_dir,
  input logic          ulpi_data_oe,
  input logic          ulpi_stp,
  input logic [CW-1:0] dly_cfg,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          tx_last,
  input logic          tx_abort
);
  logic [7:0] since_fall;
  logic       dir_p;
  logic       in_pkt;
  logic       acc;
  logic       first_acc;
  int         need;

  assign acc       = tx_valid && tx_ready;
  assign first_acc = acc && !in_pkt && !ulpi_dir;

  always_comb begin
    if (int'(dly_cfg) < DMIN)      need = DMIN;
    else if (int'(dly_cfg) > DMAX) need = DMAX;
    else                           need = int'(dly_cfg);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      since_fall <= 8'hFF;
      dir_p      <= ulpi_dir;
      in_pkt     <= 1'b0;
    end else begin
      dir_p <= ulpi_dir;
      if (dir_p && !ulpi_dir)   since_fall <= 8'd0;
      else if (since_fall != 8'hFF) since_fall <= since_fall + 8'd1;
      if (acc) in_pkt <= !tx_last;
    end
  end

  p_no_drive_dir_r1: assert property (@(posedge clk) disable iff (rst)
    ulpi_dir |-> !ulpi_data_oe);

  p_turnaround_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(ulpi_dir) |-> !ulpi_data_oe);

  p_holdoff_r3: assert property (@(posedge clk) disable iff (rst)
    first_acc |-> (int'(since_fall) >= need));

  p_stp_single_r6: assert property (@(posedge clk) disable iff (rst)
    ulpi_stp |=> !ulpi_stp);

  p_stp_after_last_r6: assert property (@(posedge clk) disable iff (rst)
    ulpi_stp |-> $past(tx_valid && tx_ready && tx_last && !ulpi_dir));

  p_abort_cause_r7: assert property (@(posedge clk) disable iff (rst)
    tx_abort |-> ($past(ulpi_dir) && !ulpi_stp));

  p_abort_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    tx_abort |=> !tx_abort);
endmodule

bind ulpi_ta_seq ulpi_ta_seq_chk #(.CW(CW), .DMIN(DMIN), .DMAX(DMAX)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ulpi_dir     (ulpi_dir),
  .ulpi_data_oe (ulpi_data_oe),
  .ulpi_stp     (ulpi_stp),
  .dly_cfg      (dly_cfg),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .tx_last      (tx_last),
  .tx_abort     (tx_abort)
);

// File: tb/ulpi_ta_seq_tb.sv
module ulpi_ta_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dir = 1'b0;
  logic       nxt = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] dout;
  logic       oe;
  logic       stp;
  logic [3:0] cfg = 4'd3;
  logic       clamped;
  logic       tvalid = 1'b0;
  logic       tready;
  logic [3:0] tdata = 4'd0;
  logic       tlast = 1'b0;
  logic       abort;
  logic       rvalid;
  logic [3:0] rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [3:0] pkt [8];

  always #4 clk = ~clk;

  ulpi_ta_seq u_dut (
    .clk(clk), .rst(rst), .ulpi_dir(dir), .ulpi_nxt(nxt), .ulpi_data_i(din),
    .ulpi_data_o(dout), .ulpi_data_oe(oe), .ulpi_stp(stp), .dly_cfg(cfg),
    .dly_clamped(clamped), .tx_valid(tvalid), .tx_ready(tready), .tx_data(tdata),
    .tx_last(tlast), .tx_abort(abort), .rx_valid(rvalid), .rx_data(rdata)
  );

  function automatic int exp_delay(input int c);
    if (c < 1) return 1;
    if (c > 14) return 14;
    return c;
  endfunction

  function automatic bit exp_flag(input int c);
    return (c < 1) || (c > 14);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finish_run();
    end
  end

  // PHY owns the bus: turnaround, nib data nibbles, then lag clocks of end delay.
  task automatic rx_burst(input int nib, input int lag);
    @(negedge clk);
    dir = 1'b1; din = 4'd0; nxt = 1'b0;
    #1 chk(oe == 1'b0, "R1", "oe with dir high", oe, 0);
    @(negedge clk);
    chk(rvalid == 1'b0, "R8", "rx_valid in turnaround", rvalid, 0);
    for (int i = 0; i < nib; i++) begin
      logic [3:0] v;
      v = 4'($urandom);
      din = v;
      @(negedge clk);
      chk(rvalid == 1'b1 && rdata == v, "R8", "rx nibble", int'(rdata), int'(v));
    end
    din = 4'd0;
    for (int i = 0; i < lag; i++) @(negedge clk);
  endtask

  task automatic exchange(input int c, input int nib, input int lag,
                          input int plen, input int abort_at);
    int d;
    int idx;
    bit acc;
    @(negedge clk);
    cfg = 4'(c);
    #1 chk(clamped == exp_flag(c), "R4", "dly_clamped", clamped, exp_flag(c));
    d = exp_delay(c);
    for (int i = 0; i < plen; i++) pkt[i] = (i == 0) ? (4'h4 | 4'($urandom % 4)) : 4'($urandom);
    rx_burst(nib, lag);
    // still at a negedge, dir high: present the command and hand the bus back
    tvalid = 1'b1; tdata = pkt[0]; tlast = (plen == 1);
    dir = 1'b0;
    #1 chk(oe == 1'b0, "R1", "oe in turnaround", oe, 0);
    chk(tready == 1'b0, "R3", "ready in turnaround", tready, 0);
    for (int j = 0; j <= d; j++) begin
      @(negedge clk);
      chk(oe == 1'b1 && dout == 4'd0 && stp == 1'b0, "R3", "idle during hold-off",
          int'(dout), 0);
      chk(tready == 1'b0, "R2", "ready while idle", tready, 0);
    end
    idx = 0; acc = 1'b0;
    forever begin
      @(negedge clk);
      if (acc) idx++;
      acc = 1'b0;
      if (idx == plen) break;
      tdata = pkt[idx]; tlast = (idx == plen - 1);
      if (idx == abort_at) begin
        dir = 1'b1; nxt = 1'b0;
        #1 chk(oe == 1'b0 && tready == 1'b0, "R7", "dir rise in transmit", tready, 0);
        @(negedge clk);
        chk(abort == 1'b1, "R7", "abort pulse", abort, 1);
        chk(stp == 1'b0, "R7", "no stp on abort", stp, 0);
        for (int k = idx; k < plen; k++) begin
          tdata = pkt[k]; tlast = (k == plen - 1);
          #1 chk(tready == 1'b1, "R7", "drain ready", tready, 1);
          @(negedge clk);
          chk(abort == 1'b0 && stp == 1'b0, "R7", "abort single cycle", abort, 0);
        end
        tvalid = 1'b0; tlast = 1'b0;
        #1 chk(tready == 1'b0, "R7", "ready after drain", tready, 0);
        dir = 1'b0;
        for (int k = 0; k < 16; k++) @(negedge clk);
        return;
      end
      nxt = 1'($urandom % 2);
      #1 chk(dout == pkt[idx], (idx == 0) ? "R3" : "R5", "bus word", int'(dout), int'(pkt[idx]));
      chk(tready == nxt, "R5", "ready follows nxt", tready, nxt);
      acc = nxt;
    end
    tvalid = 1'b0; tlast = 1'b0; nxt = 1'b0;
    #1 chk(stp == 1'b1 && dout == 4'd0, "R6", "stp after last", stp, 1);
    @(negedge clk);
    chk(stp == 1'b0 && dout == 4'd0 && oe == 1'b1, "R6", "stp one clock", stp, 0);
    chk(tready == 1'b0, "R2", "idle ready", tready, 0);
  endtask

  initial begin
    void'($urandom(32'd1506));
    repeat (3) @(negedge clk);
    chk(oe == 1'b1 && dout == 4'd0, "R9", "reset bus idle", int'(dout), 0);
    chk(stp == 1'b0 && tready == 1'b0 && abort == 1'b0 && rvalid == 1'b0,
        "R9", "reset strobes", int'({stp, tready, abort, rvalid}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(oe == 1'b1 && dout == 4'd0 && stp == 1'b0, "R2", "idle after reset", int'(dout), 0);
    // directed corners: clamp limits, worst-case lag, single-word packet
    exchange(0, 2, 8, 1, -1);
    exchange(15, 3, 8, 3, -1);
    exchange(14, 1, 3, 2, -1);
    exchange(1, 4, 5, 4, 0);
    exchange(7, 2, 8, 5, 3);
    for (int it = 0; it < 40; it++) begin
      int c, n, l, p, a;
      c = int'($urandom % 16);
      n = 1 + int'($urandom % 6);
      l = 3 + int'($urandom % 6);
      p = 1 + int'($urandom % 5);
      a = ($urandom % 6 == 0) ? int'($urandom % p) : -1;
      exchange(c, n, l, p, a);
    end
    finish_run();
  end
endmodule